// File: doc/BRIEF.md
# Block load/store address sequencer

This block sequences one multi-register memory transfer. It takes a register
selection mask, a base address, an addressing mode, a writeback request and a
load/store direction, all captured on a start strobe. It then issues one
word-sized memory request per selected register. It waits on a memory ready
handshake for each request. For a store it reads the register file, and for a
load it writes the register file.

Whatever the mode, the selected registers are visited from the lowest index
upward, and the addresses rise with them. The mode only sets where the window
of addresses sits relative to the base, and what the updated base will be.
When the last access has been accepted, the block pulses a completion strobe.
If writeback was requested, it also pulses a base-update strobe at the same
time, with the new base value.

Top module: `blkxfer_seq`

## Requirements
- R1: Selected registers are transferred in rising index order, one per accepted request, and each address is STEP (4) bytes above the previous one, so the lowest index uses the lowest address.
- R2: Mode code 2'b00 (rising, step after): the first address is the base, and the updated base is base + 4·n, where n is the number of selected registers. Base 0x1484 with three registers gives 0x1484, 0x1488, 0x148C and an updated base of 0x1490.
- R3: Mode code 2'b01 (rising, step before): the first address is base + 4, and the updated base is base + 4·n.
- R4: Mode code 2'b10 (falling, step after): the first address is base − 4·n + 4, and the updated base is base − 4·n.
- R5: Mode code 2'b11 (falling, step before): the first address is base − 4·n, and the updated base is base − 4·n. Base 0x1484 with three registers gives 0x1478, 0x147C, 0x1480 and an updated base of 0x1478. All address arithmetic wraps modulo 2^W.
- R6: `base_we` pulses together with `done` only when writeback was requested at start. `wb_value` then carries the updated base.
- R7: On a store with writeback, the selected base register sends its original register-file value when it is the lowest selected index. In every other position it sends the updated base value.
- R8: An empty selection mask issues no memory request and asserts `done` in the cycle after the start strobe.
- R9: While `mem_req` is high and `mem_rdy` is low, the request, address, index, direction and write data hold steady.
- R10: A start strobe that arrives while the block is busy is ignored, and the running transfer completes unchanged.
- R11: A store sends the register-file data for the current index on `mem_wdata` with `mem_we` high. A load writes `mem_rdata` to the current index through `rf_we` in the cycle in which the request is accepted.
- R12: After reset the block is idle, with no request and no `done`. `done` is a one-cycle pulse in the cycle after the last request is accepted, and `busy` is high from the cycle after start until `done` ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, sampled while idle |
| reg_list | input | NREG | Selection mask, one bit per register index |
| base_addr | input | W | Base address |
| base_idx | input | log2(NREG) | Index of the register that holds the base |
| mode | input | 2 | Addressing mode code (see R2–R5) |
| wb_en | input | 1 | Request an update of the base register |
| is_load | input | 1 | 1 = load from memory, 0 = store to memory |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | W | Memory byte address |
| mem_idx | output | log2(NREG) | Register index of the current request |
| mem_wdata | output | W | Store data |
| mem_rdata | input | W | Load data, valid with mem_rdy |
| mem_rdy | input | 1 | Memory accepts the current request |
| rf_rd_idx | output | log2(NREG) | Register file read index |
| rf_rd_data | input | W | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_wr_idx | output | log2(NREG) | Register file write index |
| rf_wr_data | output | W | Register file write data |
| done | output | 1 | Transfer complete pulse |
| base_we | output | 1 | Base register update strobe |
| wb_value | output | W | Updated base value |

## Verification
The bench targets the two published address examples, the falling modes near address zero where the window wraps, and an empty mask. A sequencer that walked downward in the falling modes, started one word off, or took the mask count from the wrong place would place the first word at the wrong address or report the wrong updated base. Stores that hold the base register are run with that register both lowest and not lowest; a design that got the rule backwards would send the wrong value for exactly one word. Irregular ready patterns and a start strobe that overlaps a running transfer expose a sequencer that skips a register, advances its address while stalled, or restarts partway through a transfer.

// File: rtl/blkxfer_pkg.sv
`timescale 1ns/1ps
package blkxfer_pkg;

   // bit 1 = falling window, bit 0 = step taken before the access
   typedef enum logic [1:0] {
      XM_RISE_AFTER  = 2'b00,
      XM_RISE_BEFORE = 2'b01,
      XM_FALL_AFTER  = 2'b10,
      XM_FALL_BEFORE = 2'b11
   } xfer_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'b00,
      SQ_RUN  = 2'b01,
      SQ_FIN  = 2'b10
   } seq_state_e;

endpackage

// File: rtl/blkxfer_popcnt.sv
`timescale 1ns/1ps
// Counts the set bits of a mask with a chain of partial sums.
module blkxfer_popcnt #(
   parameter int N  = 16,
   parameter int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  vec,
   output logic [CW-1:0] cnt
);
   logic [CW-1:0] part [0:N];

   assign part[0] = '0;

   for (genvar i = 0; i < N; i++) begin : g_sum
      assign part[i+1] = part[i] + CW'(vec[i]);
   end

   assign cnt = part[N];
endmodule

// File: rtl/blkxfer_lowest.sv
`timescale 1ns/1ps
// Returns the index of the lowest set bit (0 when the mask is empty).
module blkxfer_lowest #(
   parameter int N  = 16,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx
);
   logic [IW-1:0] pick [0:N];

   assign pick[N] = '0;

   for (genvar i = N - 1; i >= 0; i--) begin : g_pick
      assign pick[i] = vec[i] ? IW'(i) : pick[i+1];
   end

   assign idx = pick[0];
endmodule

// File: rtl/blkxfer_addrgen.sv
`timescale 1ns/1ps
// Places the transfer window relative to the base and computes the new base.
module blkxfer_addrgen
   import blkxfer_pkg::*;
#(
   parameter int W    = 32,
   parameter int CW   = 5,
   parameter int STEP = 4
) (
   input  logic [W-1:0]  base,
   input  xfer_mode_e    mode,
   input  logic [CW-1:0] cnt,
   output logic [W-1:0]  first_addr,
   output logic [W-1:0]  next_base
);
   localparam int SH = $clog2(STEP);

   logic [W-1:0] span;
   logic [W-1:0] low_end;
   logic [W-1:0] high_end;

   assign span     = W'(cnt) << SH;
   assign low_end  = base - span;
   assign high_end = base + span;

   always_comb begin
      unique case (mode)
         XM_RISE_AFTER: begin
            first_addr = base;
            next_base  = high_end;
         end
         XM_RISE_BEFORE: begin
            first_addr = base + W'(STEP);
            next_base  = high_end;
         end
         XM_FALL_AFTER: begin
            first_addr = low_end + W'(STEP);
            next_base  = low_end;
         end
         default: begin
            first_addr = low_end;
            next_base  = low_end;
         end
      endcase
   end
endmodule

// File: rtl/blkxfer_seq.sv
`timescale 1ns/1ps
module blkxfer_seq
   import blkxfer_pkg::*;
#(
   parameter int NREG = 16,
   parameter int W    = 32,
   parameter int STEP = 4,
   localparam int IW  = $clog2(NREG),
   localparam int CW  = $clog2(NREG + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [NREG-1:0] reg_list,
   input  logic [W-1:0]    base_addr,
   input  logic [IW-1:0]   base_idx,
   input  logic [1:0]      mode,
   input  logic            wb_en,
   input  logic            is_load,
   output logic            busy,
   output logic            mem_req,
   output logic            mem_we,
   output logic [W-1:0]    mem_addr,
   output logic [IW-1:0]   mem_idx,
   output logic [W-1:0]    mem_wdata,
   input  logic [W-1:0]    mem_rdata,
   input  logic            mem_rdy,
   output logic [IW-1:0]   rf_rd_idx,
   input  logic [W-1:0]    rf_rd_data,
   output logic            rf_we,
   output logic [IW-1:0]   rf_wr_idx,
   output logic [W-1:0]    rf_wr_data,
   output logic            done,
   output logic            base_we,
   output logic [W-1:0]    wb_value
);
   // elaboration-time parameter checks
   if (NREG < 2) begin : g_bad_nreg
      $error("blkxfer_seq: NREG must be at least 2");
   end
   if ((STEP < 1) || ((STEP & (STEP - 1)) != 0)) begin : g_bad_step
      $error("blkxfer_seq: STEP must be a power of two");
   end
   if (W < 8) begin : g_bad_w
      $error("blkxfer_seq: W must be at least 8");
   end

   xfer_mode_e      mode_e;
   seq_state_e      state;
   logic [NREG-1:0] remain;
   logic [NREG-1:0] remain_nxt;
   logic [W-1:0]    cur_addr;
   logic [W-1:0]    wb_val_q;
   logic [IW-1:0]   bidx_q;
   logic [IW-1:0]   first_q;
   logic            wb_q;
   logic            load_q;

   logic [CW-1:0]   list_cnt;
   logic [IW-1:0]   list_first;
   logic [IW-1:0]   cur_idx;
   logic [W-1:0]    start_addr;
   logic [W-1:0]    new_base;
   logic            use_new_base;
   logic            accept;

   assign mode_e = xfer_mode_e'(mode);

   blkxfer_popcnt #(.N(NREG), .CW(CW)) u_cnt (
      .vec (reg_list),
      .cnt (list_cnt)
   );

   blkxfer_lowest #(.N(NREG), .IW(IW)) u_first (
      .vec (reg_list),
      .idx (list_first)
   );

   blkxfer_lowest #(.N(NREG), .IW(IW)) u_cur (
      .vec (remain),
      .idx (cur_idx)
   );

   blkxfer_addrgen #(.W(W), .CW(CW), .STEP(STEP)) u_addr (
      .base       (base_addr),
      .mode       (mode_e),
      .cnt        (list_cnt),
      .first_addr (start_addr),
      .next_base  (new_base)
   );

   // clear the lowest remaining bit
   assign remain_nxt = remain & (remain - NREG'(1));
   assign accept     = (state == SQ_RUN) && mem_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         remain   <= '0;
         cur_addr <= '0;
         wb_val_q <= '0;
         bidx_q   <= '0;
         first_q  <= '0;
         wb_q     <= 1'b0;
         load_q   <= 1'b0;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (start) begin
                  remain   <= reg_list;
                  cur_addr <= start_addr;
                  wb_val_q <= new_base;
                  bidx_q   <= base_idx;
                  first_q  <= list_first;
                  wb_q     <= wb_en;
                  load_q   <= is_load;
                  state    <= (reg_list == '0) ? SQ_FIN : SQ_RUN;
               end
            end
            SQ_RUN: begin
               if (accept) begin
                  remain   <= remain_nxt;
                  cur_addr <= cur_addr + W'(STEP);
                  if (remain_nxt == '0) begin
                     state <= SQ_FIN;
                  end
               end
            end
            SQ_FIN: state <= SQ_IDLE;
            default: state <= SQ_IDLE;
         endcase
      end
   end

   // base register on a store with writeback: original value only when first
   assign use_new_base = !load_q && wb_q && (cur_idx == bidx_q) && (cur_idx != first_q);

   assign busy       = (state != SQ_IDLE);
   assign mem_req    = (state == SQ_RUN);
   assign mem_we     = mem_req && !load_q;
   assign mem_addr   = cur_addr;
   assign mem_idx    = cur_idx;
   assign mem_wdata  = use_new_base ? wb_val_q : rf_rd_data;
   assign rf_rd_idx  = cur_idx;
   assign rf_we      = accept && load_q;
   assign rf_wr_idx  = cur_idx;
   assign rf_wr_data = mem_rdata;
   assign done       = (state == SQ_FIN);
   assign base_we    = done && wb_q;
   assign wb_value   = wb_val_q;
endmodule

// File: rtl/blkxfer_seq_chk.sv
`timescale 1ns/1ps
module blkxfer_seq_chk #(
   parameter int NREG = 16,
   parameter int W    = 32,
   parameter int STEP = 4,
   localparam int IW  = $clog2(NREG)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          mem_req,
   input logic          mem_we,
   input logic [W-1:0]  mem_addr,
   input logic [IW-1:0] mem_idx,
   input logic          mem_rdy,
   input logic          rf_we,
   input logic          done,
   input logic          base_we
);
   // R1: consecutive accesses of one transfer step up by STEP
   assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_rdy) |=> (!mem_req || (mem_addr == $past(mem_addr) + W'(STEP))));

   // R1: register index strictly rises within a transfer
   assert_idx_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_rdy) |=> (!mem_req || (mem_idx > $past(mem_idx))));

   // R9: a stalled request holds
   assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_idx) && $stable(mem_we)));

   // R12: completion is a single-cycle pulse
   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12: no request and no completion while idle
   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !done));

   // R6: base update only together with completion
   assert_base_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
      base_we |-> done);

   // R11: register writes only on accepted load requests
   assert_rf_we_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (mem_req && mem_rdy && !mem_we));
endmodule

bind blkxfer_seq blkxfer_seq_chk #(.NREG(NREG), .W(W), .STEP(STEP)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_idx  (mem_idx),
   .mem_rdy  (mem_rdy),
   .rf_we    (rf_we),
   .done     (done),
   .base_we  (base_we)
);

// File: tb/sim_blkxfer_seq.sv
`timescale 1ns/1ps
module sim_blkxfer_seq;
   localparam int NREG = 16;
   localparam int W    = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] reg_list = '0;
   logic [31:0] base_addr = '0;
   logic [3:0]  base_idx = '0;
   logic [1:0]  mode = '0;
   logic        wb_en = 1'b0;
   logic        is_load = 1'b0;
   logic        mem_rdy = 1'b0;
   logic        busy, mem_req, mem_we, rf_we, done, base_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data, wb_value;
   logic [3:0]  mem_idx, rf_rd_idx, rf_wr_idx;

   always #10 clk = ~clk;   // 50 MHz

   assign mem_rdata  = mem_addr ^ 32'h5A5A_0F0F;
   assign rf_rd_data = 32'hC000_0000 | (32'(rf_rd_idx) * 32'h101);

   blkxfer_seq #(.NREG(NREG), .W(W), .STEP(4)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .reg_list(reg_list),
      .base_addr(base_addr), .base_idx(base_idx), .mode(mode), .wb_en(wb_en),
      .is_load(is_load), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_idx(mem_idx), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .rf_rd_idx(rf_rd_idx),
      .rf_rd_data(rf_rd_data), .rf_we(rf_we), .rf_wr_idx(rf_wr_idx),
      .rf_wr_data(rf_wr_data), .done(done), .base_we(base_we), .wb_value(wb_value)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit chk_en = 1'b0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic string mtag(input int m);
      case (m)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         default: return "R5";
      endcase
   endfunction

   // ---------------- behavioural reference model ----------------
   typedef struct { int idx; logic [31:0] addr; logic [31:0] data; } ent_t;
   ent_t        q[$];
   int          ms = 0;          // 0 idle, 1 transferring, 2 completing
   bit          m_load, m_wb;
   logic [31:0] m_wbv;
   int          m_n, m_bidx, m_mode;
   string       cur_tag = "R12";
   int          rdy_mode = 0;
   logic [31:0] cap[$];
   logic [31:0] last_wbv;

   task automatic model_build();
      logic [31:0] a, span;
      int lowest;
      m_load = is_load;
      m_wb   = wb_en;
      m_bidx = int'(base_idx);
      m_mode = int'(mode);
      m_n    = $countones(reg_list);
      span   = 32'(m_n) * 32'd4;
      case (m_mode)
         0: begin a = base_addr;              m_wbv = base_addr + span; end
         1: begin a = base_addr + 32'd4;      m_wbv = base_addr + span; end
         2: begin a = base_addr - span + 32'd4; m_wbv = base_addr - span; end
         default: begin a = base_addr - span; m_wbv = base_addr - span; end
      endcase
      lowest = -1;
      for (int i = 15; i >= 0; i--) if (reg_list[i]) lowest = i;
      q.delete();
      for (int i = 0; i < 16; i++) begin
         if (reg_list[i]) begin
            ent_t e;
            e.idx  = i;
            e.addr = a;
            if (!m_load && m_wb && i == m_bidx && i != lowest) e.data = m_wbv;
            else e.data = 32'hC000_0000 | (32'(i) * 32'h101);
            q.push_back(e);
            a = a + 32'd4;
         end
      end
      ms = (m_n == 0) ? 2 : 1;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         ms = 0;
         q.delete();
      end else begin
         case (ms)
            0: if (start) model_build();
            1: if (mem_rdy) begin
                  void'(q.pop_front());
                  if (q.size() == 0) ms = 2;
               end
            default: ms = 0;
         endcase
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (chk_en && !finished) begin
         chk(busy == (ms != 0), cur_tag, "busy", 32'(busy), 32'(ms != 0));
         chk(mem_req == (ms == 1), (m_n == 0) ? "R8" : cur_tag, "mem_req", 32'(mem_req), 32'(ms == 1));
         chk(done == (ms == 2), (m_n == 0) ? "R8" : "R12", "done", 32'(done), 32'(ms == 2));
         if (ms == 2) begin
            chk(base_we == m_wb, "R6", "base_we", 32'(base_we), 32'(m_wb));
            if (m_wb) chk(wb_value == m_wbv, mtag(m_mode), "wb_value", wb_value, m_wbv);
            last_wbv = wb_value;
         end else begin
            chk(base_we == 1'b0, "R6", "base_we idle", 32'(base_we), 32'd0);
         end
         if (ms == 1 && q.size() > 0) begin
            chk(mem_addr == q[0].addr, mem_rdy ? mtag(m_mode) : "R9", "mem_addr", mem_addr, q[0].addr);
            chk(int'(mem_idx) == q[0].idx, "R1", "mem_idx", 32'(mem_idx), 32'(q[0].idx));
            chk(mem_we == !m_load, "R11", "mem_we", 32'(mem_we), 32'(!m_load));
            if (!m_load)
               chk(mem_wdata == q[0].data, (q[0].idx == m_bidx) ? "R7" : "R11",
                   "mem_wdata", mem_wdata, q[0].data);
            chk(rf_we == (m_load && mem_rdy), "R11", "rf_we", 32'(rf_we), 32'(m_load && mem_rdy));
            if (m_load && mem_rdy) begin
               chk(rf_wr_data == (q[0].addr ^ 32'h5A5A_0F0F), "R11", "rf_wr_data",
                   rf_wr_data, q[0].addr ^ 32'h5A5A_0F0F);
               chk(int'(rf_wr_idx) == q[0].idx, "R11", "rf_wr_idx", 32'(rf_wr_idx), 32'(q[0].idx));
            end
            if (mem_rdy) cap.push_back(mem_addr);
         end else begin
            chk(rf_we == 1'b0, "R11", "rf_we idle", 32'(rf_we), 32'd0);
         end
      end
   end

   // ready pattern driver
   initial begin
      forever begin
         @(posedge clk);
         #2;
         case (rdy_mode)
            0: mem_rdy = 1'b1;
            1: mem_rdy = ($urandom % 3) != 0;
            default: mem_rdy = ~mem_rdy;
         endcase
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while (ms != 0) @(negedge clk);
   endtask

   task automatic run_op(input logic [15:0] lst, input logic [31:0] b, input int bi,
                         input int m, input bit wb, input bit ld, input string tag);
      @(posedge clk); #2;
      cur_tag   = tag;
      reg_list  = lst;
      base_addr = b;
      base_idx  = 4'(bi);
      mode      = 2'(m);
      wb_en     = wb;
      is_load   = ld;
      start     = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
      wait_idle();
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_up();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12: state held in reset
      chk(busy == 0 && mem_req == 0 && done == 0, "R12", "reset idle",
          {29'd0, busy, mem_req, done}, 32'd0);
      @(posedge clk); #2;
      rst_n = 1'b1;
      chk_en = 1'b1;

      // R2: rising, step after, worked example
      cap.delete();
      run_op(16'h000E, 32'h0000_1484, 0, 0, 1, 1, "R12");
      chk(cap.size() == 3, "R2", "access count", 32'(cap.size()), 32'd3);
      if (cap.size() == 3) begin
         chk(cap[0] == 32'h1484, "R2", "addr0", cap[0], 32'h1484);
         chk(cap[1] == 32'h1488, "R2", "addr1", cap[1], 32'h1488);
         chk(cap[2] == 32'h148C, "R2", "addr2", cap[2], 32'h148C);
      end
      chk(last_wbv == 32'h1490, "R2", "new base", last_wbv, 32'h1490);

      // R5: falling, step before, worked example
      cap.delete();
      run_op(16'h000E, 32'h0000_1484, 0, 3, 1, 1, "R12");
      chk(cap.size() == 3, "R5", "access count", 32'(cap.size()), 32'd3);
      if (cap.size() == 3) begin
         chk(cap[0] == 32'h1478, "R5", "addr0", cap[0], 32'h1478);
         chk(cap[1] == 32'h147C, "R5", "addr1", cap[1], 32'h147C);
         chk(cap[2] == 32'h1480, "R5", "addr2", cap[2], 32'h1480);
      end
      chk(last_wbv == 32'h1478, "R5", "new base", last_wbv, 32'h1478);

      // R3 and R6: rising, step before, store without writeback
      run_op(16'h8421, 32'h0000_2000, 0, 1, 0, 0, "R6");
      // R4 and R9: falling, step after, full mask, irregular ready
      rdy_mode = 1;
      run_op(16'hFFFF, 32'h0001_0000, 0, 2, 1, 1, "R9");
      // R7: base register lowest in a store with writeback
      rdy_mode = 0;
      run_op(16'h00F0, 32'h0000_3000, 4, 0, 1, 0, "R7");
      // R7: base register not lowest
      run_op(16'h00F0, 32'h0000_3000, 6, 3, 1, 0, "R7");
      // R8: empty mask
      run_op(16'h0000, 32'h0000_4000, 2, 1, 1, 0, "R8");
      run_op(16'h0000, 32'h0000_4000, 2, 3, 0, 1, "R8");
      // R5: falling window wraps below zero
      run_op(16'h0007, 32'h0000_0004, 1, 3, 1, 0, "R5");

      // R10: start pulse while busy is ignored
      rdy_mode = 2;
      @(posedge clk); #2;
      cur_tag = "R10"; reg_list = 16'h0303; base_addr = 32'h0000_5000; base_idx = 4'd9;
      mode = 2'd0; wb_en = 1'b1; is_load = 1'b0; start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
      @(posedge clk); #2;
      reg_list = 16'hFFFF; base_addr = 32'h0000_9000; mode = 2'd3; start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
      wait_idle();

      // mixed traffic
      rdy_mode = 1;
      for (int k = 0; k < 40; k++) begin
         run_op(16'($urandom), $urandom & 32'hFFFF_FFFC, int'($urandom % 16),
                int'($urandom % 4), 1'($urandom), 1'($urandom), "R12");
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      finish_up();
   end
endmodule